// File: doc/BRIEF.md
# Majority-Clocked Triple-LFSR Keystream Generator

This block is a synchronous stream-cipher keystream source built from three linear feedback shift registers of 19, 22 and 23 bits. A keystream bit is the XOR of the three register MSBs. The same bit is XORed with a data bit to give ciphertext or plaintext. Encryption and decryption are the same operation, so two ends seeded with the same key recover the data.

Operation has two phases. A load strobe captures a 64-bit key, clears all three registers and holds the busy flag high for 64 cycles. In each of those cycles every register steps, with one key bit (LSB first) XORed into its feedback. In the run phase, each cycle with the keystream enable high uses up one keystream bit. A majority vote over one middle bit of each register then decides which registers step. A register steps only when its own voting bit agrees with the majority.

Top module: `maj_lfsr_keygen`

## Requirements
- R1: After reset, busy_o is 0, ks_bit_o is 0 and data_o is 0.
- R2: A load_i pulse while idle raises busy_o in the next cycle. busy_o then stays high for exactly 64 cycles.
- R3: The load clears all registers, then steps every register on each of the 64 busy cycles. Key bit k (key_i bit k, k = 0 first) is XORed into each register's feedback on busy cycle k. An all-zero key therefore leaves a keystream of constant 0.
- R4: Feedback is the XOR of bits 18,17,16,13 for the 19-bit register, of bits 21,20 for the 22-bit register, and of bits 22,21,20,7 for the 23-bit register. The feedback bit enters at bit 0 and the other bits shift up by one.
- R5: On a run cycle (idle, ks_en_i=1, load_i=0) the voting bits are bit 8, bit 10 and bit 10 of the 19-, 22- and 23-bit registers. The majority is 1 when two or more voting bits are 1. Each register steps only if its voting bit equals the majority.
- R6: ks_bit_o is always the XOR of bit 18, bit 21 and bit 22 of the three current registers.
- R7: On a run cycle, data_o takes data_i XOR ks_bit_o one cycle later. On any other cycle data_o holds.
- R8: ks_en_i and load_i have no effect while busy_o is high. load_i has priority over ks_en_i when idle.
- R9: When idle with ks_en_i=0, the registers hold, so ks_bit_o is stable.
- R10: Reloading the same key restarts the same keystream. Feeding the ciphertext back through that keystream returns the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_i | input | 64 | Key, captured on an accepted load |
| load_i | input | 1 | Load-start strobe |
| busy_o | output | 1 | High during the 64-cycle load phase |
| ks_en_i | input | 1 | Keystream enable: consume one bit and step |
| ks_bit_o | output | 1 | Current keystream bit |
| data_i | input | 1 | Plaintext or ciphertext bit in |
| data_o | output | 1 | Registered data_i XOR keystream |

## Verification
The assertions assume that inputs change only away from the rising edge. They also assume that load_i and ks_en_i are single-bit values that are never unknown after reset. The bench drives every input on the falling edge from known values and keeps all strobes low while the internal reset synchronizer releases. The bench deliberately drives load_i and ks_en_i during the busy phase, and it compares the result against a behavioural reference on every clock. This exercises the property that the block ignores those inputs while busy.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
  localparam int NUM_REG = 3;
  localparam int KEY_W   = 64;
  localparam int CNT_W   = $clog2(KEY_W);
  localparam int MAX_LEN = 32;

  localparam int REG_LEN [NUM_REG] = '{19, 22, 23};
  localparam int REG_VOTE[NUM_REG] = '{8, 10, 10};
  localparam logic [MAX_LEN-1:0] REG_TAPS[NUM_REG] = '{
    32'h0007_2000,   // bits 18,17,16,13
    32'h0030_0000,   // bits 21,20
    32'h0070_0080    // bits 22,21,20,7
  };
endpackage

// File: rtl/keygen_lfsr_stage.sv
module keygen_lfsr_stage #(
  parameter int                LEN      = 19,
  parameter logic [31:0]       TAPS     = 32'h0007_2000,
  parameter int                VOTE_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  input  logic inject_i,
  output logic msb_o,
  output logic vote_o
);
  localparam logic [LEN-1:0] MASK = TAPS[LEN-1:0];

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_d;
  logic           state_en;
  logic           fb;

  always_comb begin
    fb       = (^(state_q & MASK)) ^ inject_i;
    state_en = clear_i | step_i;
    state_d  = state_q;
    if (clear_i)     state_d = '0;
    else if (step_i) state_d = {state_q[LEN-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign msb_o  = state_q[LEN-1];
  assign vote_o = state_q[VOTE_BIT];

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (state_q == '0));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !step_i) |=> $stable(state_q));
endmodule

// File: rtl/keygen_majority.sv
module keygen_majority #(
  parameter int N = 3
) (
  input  logic [N-1:0] votes_i,
  output logic         maj_o,
  output logic [N-1:0] agree_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(votes_i[i]);
    maj_o = (ones > CW'(N / 2));
  end

  for (genvar g = 0; g < N; g++) begin : g_agree
    assign agree_o[g] = (votes_i[g] == maj_o);
  end
endmodule

// File: rtl/keygen_load_seq.sv
module keygen_load_seq
  import keygen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             key_bit_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             seq_en;
  logic             last;

  always_comb begin
    start_o = load_i & ~busy_q;
    last    = (cnt_q == CNT_W'(KEY_W - 1));
    seq_en  = start_o | busy_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    key_d   = key_q;
    if (start_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      key_d  = key_i;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      key_d = key_q >> 1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      key_q  <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      key_q  <= key_d;
    end
  end

  assign busy_o    = busy_q;
  assign key_bit_o = key_q[0];

  assert_load_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == CNT_W'(KEY_W - 1)));
  assert_busy_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);
endmodule

// File: rtl/maj_lfsr_keygen.sv
module maj_lfsr_keygen
  import keygen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic             load_i,
  output logic             busy_o,
  input  logic             ks_en_i,
  output logic             ks_bit_o,
  input  logic             data_i,
  output logic             data_o
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic               start, busy, key_bit, run_en, maj;
  logic [NUM_REG-1:0] msb, vote, agree, step;

  keygen_load_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load_i),
    .key_i    (key_i),
    .start_o  (start),
    .busy_o   (busy),
    .key_bit_o(key_bit)
  );

  keygen_majority #(.N(NUM_REG)) u_maj (
    .votes_i(vote),
    .maj_o  (maj),
    .agree_o(agree)
  );

  assign run_en = ks_en_i & ~busy & ~load_i;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    assign step[g] = busy | (run_en & agree[g]);
    keygen_lfsr_stage #(
      .LEN     (REG_LEN[g]),
      .TAPS    (REG_TAPS[g]),
      .VOTE_BIT(REG_VOTE[g])
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clear_i (start),
      .step_i  (step[g]),
      .inject_i(busy & key_bit),
      .msb_o   (msb[g]),
      .vote_o  (vote[g])
    );
  end

  assign ks_bit_o = ^msb;
  assign busy_o   = busy;

  logic data_d;
  always_comb data_d = data_i ^ ks_bit_o;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  data_o <= 1'b0;
    else if (run_en)  data_o <= data_d;
  end

  assert_two_step_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_en |-> ($countones(step) >= 2));
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_en |=> $stable(data_o));
  assert_busy_ignores_en_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && ks_en_i) |=> $stable(data_o));
  assert_idle_ks_stable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && !ks_en_i && !load_i) |=> $stable(ks_bit_o));
endmodule

// File: tb/tb_maj_lfsr_keygen.sv
module tb_maj_lfsr_keygen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] key_i = '0;
  logic        load_i = 1'b0, ks_en_i = 1'b0, data_i = 1'b0;
  logic        busy_o, ks_bit_o, data_o;

  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  maj_lfsr_keygen dut (.clk(clk), .rst_n(rst_n), .key_i(key_i), .load_i(load_i),
    .busy_o(busy_o), .ks_en_i(ks_en_i), .ks_bit_o(ks_bit_o), .data_i(data_i),
    .data_o(data_o));

  // behavioural reference
  logic [18:0] m1; logic [21:0] m2; logic [22:0] m3;
  logic [63:0] m_key; int m_cnt; logic m_busy, m_data;
  logic b, f1, f2, f3, ks, mj; int votes;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = '0; m2 = '0; m3 = '0; m_key = '0; m_cnt = 0; m_busy = 0; m_data = 0;
    end else if (m_busy) begin
      b  = m_key[m_cnt];
      f1 = m1[18] ^ m1[17] ^ m1[16] ^ m1[13] ^ b;
      f2 = m2[21] ^ m2[20] ^ b;
      f3 = m3[22] ^ m3[21] ^ m3[20] ^ m3[7] ^ b;
      m1 = {m1[17:0], f1}; m2 = {m2[20:0], f2}; m3 = {m3[21:0], f3};
      m_cnt++;
      if (m_cnt == 64) m_busy = 0;
    end else if (load_i) begin
      m_key = key_i; m1 = '0; m2 = '0; m3 = '0; m_cnt = 0; m_busy = 1;
    end else if (ks_en_i) begin
      ks = m1[18] ^ m2[21] ^ m3[22];
      m_data = data_i ^ ks;
      votes = int'(m1[8]) + int'(m2[10]) + int'(m3[10]);
      mj = (votes >= 2);
      f1 = m1[18] ^ m1[17] ^ m1[16] ^ m1[13];
      f2 = m2[21] ^ m2[20];
      f3 = m3[22] ^ m3[21] ^ m3[20] ^ m3[7];
      if (m1[8]  == mj) m1 = {m1[17:0], f1};
      if (m2[10] == mj) m2 = {m2[20:0], f2};
      if (m3[10] == mj) m3 = {m3[21:0], f3};
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); cyc++;
    chk("R2 busy", busy_o, m_busy);
    chk("R3/R4/R5/R6 keystream", ks_bit_o, m1[18] ^ m2[21] ^ m3[22]);
    chk("R7 data", data_o, m_data);
  endtask

  task automatic do_load(input logic [63:0] k, input bit poke);
    int n = 0;
    key_i = k; load_i = 1; tick(); load_i = 0; key_i = ~k;
    while (busy_o) begin
      n++;
      if (poke && n == 20) begin load_i = 1; ks_en_i = 1; data_i = 1; end
      if (poke && n == 21) begin load_i = 0; end
      tick();
    end
    ks_en_i = 0;
    checks++;
    if (n != 64) begin errors++; $display("FAIL R2/R8 busy length: actual=%0d expected=64", n); end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [47:0] pt, ct;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 ks", ks_bit_o, 1'b0);
    chk("R1 data", data_o, 1'b0);

    // load with enable/load poked during busy (R8)
    do_load(64'h0123_4567_89AB_CDEF, 1'b1);
    chk("R8 data held through busy", data_o, 1'b0);
    for (int i = 0; i < 200; i++) begin
      ks_en_i = 1; data_i = 1'($urandom); tick();
    end

    // enable gaps (R9) and load+enable same cycle (R8 priority)
    for (int i = 0; i < 200; i++) begin
      ks_en_i = 1'($urandom); data_i = 1'($urandom);
      prev = ks_bit_o;
      tick();
      if (!ks_en_i) chk("R9 ks stable when disabled", ks_bit_o, prev);
    end
    ks_en_i = 1;
    do_load(64'hDEAD_BEEF_0F1E_2D3C, 1'b0);

    // zero key: constant zero keystream (R3)
    do_load(64'h0, 1'b0);
    for (int i = 0; i < 50; i++) begin
      ks_en_i = 1; data_i = 1'($urandom); tick();
      chk("R3 zero key keystream", ks_bit_o, 1'b0);
    end
    ks_en_i = 0;

    do_load(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    for (int i = 0; i < 100; i++) begin
      ks_en_i = 1; data_i = 1'($urandom); tick();
    end
    ks_en_i = 0;

    // round trip (R10)
    pt = {$urandom, $urandom};
    do_load(64'h5A5A_1234_C3C3_9876, 1'b0);
    for (int i = 0; i < 48; i++) begin
      ks_en_i = 1; data_i = pt[i]; tick(); ct[i] = data_o;
    end
    ks_en_i = 0;
    do_load(64'h5A5A_1234_C3C3_9876, 1'b0);
    for (int i = 0; i < 48; i++) begin
      ks_en_i = 1; data_i = ct[i]; tick();
      chk("R10 decrypt round trip", data_o, pt[i]);
    end
    ks_en_i = 0; tick();
    finish_run();
  end
endmodule